// File: doc/BRIEF.md
# Framed SPI Packet Exchange Engine

This block is an SPI master (mode 0) that carries out a whole framed, full-duplex packet exchange with one slave on its own. The host writes an outgoing payload into a local transmit buffer, presents its length, and pulses `start`. The engine then pulls chip select low and keeps it low for the whole exchange. It runs five phases back to back, and each one waits only for the bytes returned in the phase before it. First it waits for the slave to signal ready. Then the two sides swap lengths and move the payload. A CRC byte follows, and a final handshake accepts or rejects the frame.

When either side rejects the frame, the engine starts again from the ready-wait phase without releasing chip select. The number of such retries is bounded, and a slave that never becomes ready is detected by a byte-count timeout. At the end the engine raises chip select and pulses `done` together with a status code. Received payload bytes are stored in a receive buffer, which the host reads through a synchronous read port. The received length is reported on `rx_len`.

Top module: `spi_pkt_engine`

## Requirements
- R1: While reset is high, and afterwards until `start`, the outputs are: `cs_n` = 1, `sclk` = 0, `done` = 0, `busy` = 0, `status` = 0, `rx_len` = 0.
- R2: SPI mode 0. `sclk` idles low, `mosi` changes only while `sclk` is low, `miso` is sampled on the rising edge, and bytes go most significant bit first.
- R3: After `start` the engine sends 0xFF and stays in the ready-wait phase until the byte it receives is 0xFF. `cs_n` stays low from `start` until the end, with exactly one rising edge per exchange.
- R4: The byte after the 0xFF is the length byte. The engine sends the `tx_len` latched at `start`, and the byte it receives is the slave's length (0 means no data).
- R5: The payload phase moves max(local length, received length) bytes, and the shorter side pads with 0x00. It is skipped when both lengths are 0. Received byte i (i < received length) is stored at receive-buffer address i. `rx_rd_data` shows the byte at `rx_rd_addr` one clock later.
- R6: After the payload the engine sends a CRC-8 (polynomial 0x07, initial value 0x00, MSB first). It covers the length byte and every payload byte it sent, pads included. The received CRC is checked against the same CRC over the bytes received in those phases.
- R7: In the handshake byte the engine sends 0xA5 when the received CRC matched and 0x5A otherwise. Any received value other than 0xA5 counts as a rejection.
- R8: If either side sends a rejection, the exchange restarts at the ready-wait phase with `cs_n` still low. After `RETRY_LIMIT` retries have all failed, the exchange ends with status 1.
- R9: If `SYNC_LIMIT` bytes in a row within one attempt come back not equal to 0xFF, the exchange ends with status 2 and `rx_len` = 0.
- R10: `done` is a one-clock pulse, and status 0 means success. `status` and `rx_len` change only in the cycle `done` is high, so `rx_len` keeps its old value during the next exchange.
- R11: Received payload bytes at index `BUF_DEPTH` or above are not stored but still enter the CRC check. `rx_len` still reports the full received length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exchange (taken only when idle) |
| tx_len | input | 8 | Outgoing payload length, at most BUF_DEPTH |
| tx_wr_en | input | 1 | Transmit buffer write enable |
| tx_wr_addr | input | AW | Transmit buffer write address |
| tx_wr_data | input | 8 | Transmit buffer write data |
| rx_rd_addr | input | AW | Receive buffer read address |
| rx_rd_data | output | 8 | Receive buffer read data, one cycle latency |
| rx_len | output | 8 | Length received from the slave |
| done | output | 1 | End-of-exchange pulse |
| status | output | 2 | 0 ok, 1 retries exhausted, 2 ready-wait timeout |
| busy | output | 1 | Exchange in progress |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Slave data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The assertions assume the following about the inputs. `tx_len` never exceeds `BUF_DEPTH`, the transmit buffer is not written while `busy` is high, and the slave changes `miso` only after falling edges of `sclk`. The bench keeps to these rules. It loads the buffer and length only while the engine is idle, and its behavioural slave updates `miso` solely on the falling edges of `sclk`. The slave follows the protocol phase by phase and records what the master sent. It can be told to delay readiness, never become ready, corrupt its CRC, or reject the handshake with 0x5A or with another value.

// File: rtl/spx_pkg.sv
package spx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_LEN,
    PH_PAY,
    PH_CRC,
    PH_ACK
  } phase_t;

  typedef enum logic [1:0] {
    ST_OK              = 2'd0,
    ST_RETRY_EXHAUSTED = 2'd1,
    ST_SYNC_TIMEOUT    = 2'd2
  } status_t;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;
  localparam logic [7:0] ACK_BYTE  = 8'hA5;
  localparam logic [7:0] NACK_BYTE = 8'h5A;
  localparam logic [7:0] PAD_BYTE  = 8'h00;
  localparam logic [7:0] CRC_POLY  = 8'h07;

  // one byte through a CRC-8, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) begin
      if (r[7]) r = {r[6:0], 1'b0} ^ CRC_POLY;
      else      r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/spx_byte_shifter.sv
module spx_byte_shifter #(
  parameter int HALF_DIV = 2,
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       active
);

  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
      div_cnt <= '0;
      bit_cnt <= '0;
      sh      <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          sh      <= tx_byte;
          mosi    <= tx_byte[7];
          div_cnt <= '0;
          bit_cnt <= '0;
        end
      end else if (div_cnt != DW'(HALF_DIV - 1)) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sh      <= {sh[6:0], 1'b0};
            mosi    <= sh[6];
          end
        end
      end
    end
  end

  // R2: data to the slave is steady whenever the clock is high
  a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

  // R2: clock rests low between bytes
  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    (!active && !$past(active)) |-> !sclk);

  // R2: a finished byte leaves the clock low
  a_r2_done_sclk_low: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sclk && !active));

endmodule

// File: rtl/spx_crc8.sv
module spx_crc8
  import spx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || clr)  crc <= 8'h00;
    else if (en)     crc <= crc8_step(crc, din);
  end

endmodule

// File: rtl/spx_ram.sv
module spx_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_pkt_engine.sv
module spi_pkt_engine
  import spx_pkg::*;
#(
  parameter int BUF_DEPTH   = 256,
  parameter int HALF_DIV    = 2,
  parameter int RETRY_LIMIT = 8,
  parameter int SYNC_LIMIT  = 256,
  localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    tx_len,
  input  logic          tx_wr_en,
  input  logic [AW-1:0] tx_wr_addr,
  input  logic [7:0]    tx_wr_data,
  input  logic [AW-1:0] rx_rd_addr,
  output logic [7:0]    rx_rd_data,
  output logic [7:0]    rx_len,
  output logic          done,
  output logic [1:0]    status,
  output logic          busy,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          cs_n
);

  localparam int RW = $clog2(RETRY_LIMIT + 1);
  localparam int SW = $clog2(SYNC_LIMIT + 1);

  phase_t        ph;
  logic          inflight, hold;
  logic [7:0]    tlen, rlen_cur, pay_n, pay_idx;
  logic [RW-1:0] retries;
  logic [SW-1:0] sync_cnt;
  logic          crc_ok;

  logic          go, sh_done, sh_active;
  logic [7:0]    tx_byte, rx_byte, tx_q, tx_crc, rx_crc, big_n;
  logic          frame_good, retry_now, crc_clr, rx_we;

  assign busy = (ph != PH_IDLE);

  // ---------------- byte shifter ----------------
  spx_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst), .go(go), .tx_byte(tx_byte), .miso(miso),
    .sclk(sclk), .mosi(mosi), .done(sh_done), .rx_byte(rx_byte), .active(sh_active)
  );

  // ---------------- buffers ----------------
  spx_ram #(.DEPTH(BUF_DEPTH), .AW(AW)) u_txbuf (
    .clk(clk), .we(tx_wr_en), .waddr(tx_wr_addr), .wdata(tx_wr_data),
    .raddr(pay_idx[AW-1:0]), .rdata(tx_q)
  );

  assign rx_we = sh_done && (ph == PH_PAY) && (pay_idx < rlen_cur)
                 && (int'(pay_idx) < BUF_DEPTH);

  spx_ram #(.DEPTH(BUF_DEPTH), .AW(AW)) u_rxbuf (
    .clk(clk), .we(rx_we), .waddr(pay_idx[AW-1:0]), .wdata(rx_byte),
    .raddr(rx_rd_addr), .rdata(rx_rd_data)
  );

  // ---------------- CRC units ----------------
  assign frame_good = crc_ok && (rx_byte == ACK_BYTE);
  assign retry_now  = sh_done && (ph == PH_ACK) && !frame_good
                      && (retries != RW'(RETRY_LIMIT));
  assign crc_clr    = ((ph == PH_IDLE) && start) || retry_now;

  spx_crc8 u_txcrc (
    .clk(clk), .rst(rst), .clr(crc_clr),
    .en(go && ((ph == PH_LEN) || (ph == PH_PAY))),
    .din(tx_byte), .crc(tx_crc)
  );

  spx_crc8 u_rxcrc (
    .clk(clk), .rst(rst), .clr(crc_clr),
    .en(sh_done && ((ph == PH_LEN) || (ph == PH_PAY))),
    .din(rx_byte), .crc(rx_crc)
  );

  // ---------------- outgoing byte select ----------------
  always_comb begin
    unique case (ph)
      PH_LEN:  tx_byte = tlen;
      PH_PAY:  tx_byte = (pay_idx < tlen) ? tx_q : PAD_BYTE;
      PH_CRC:  tx_byte = tx_crc;
      PH_ACK:  tx_byte = crc_ok ? ACK_BYTE : NACK_BYTE;
      default: tx_byte = SYNC_BYTE;
    endcase
  end

  assign go    = busy && !inflight && !hold && !sh_active;
  assign big_n = (rx_byte > tlen) ? rx_byte : tlen;

  // ---------------- phase sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      inflight <= 1'b0;
      hold     <= 1'b0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      status   <= ST_OK;
      rx_len   <= '0;
      tlen     <= '0;
      rlen_cur <= '0;
      pay_n    <= '0;
      pay_idx  <= '0;
      retries  <= '0;
      sync_cnt <= '0;
      crc_ok   <= 1'b0;
    end else begin
      done <= 1'b0;
      hold <= 1'b0;
      if (go) inflight <= 1'b1;
      if (ph == PH_IDLE) begin
        if (start) begin
          ph       <= PH_SYNC;
          cs_n     <= 1'b0;
          tlen     <= tx_len;
          retries  <= '0;
          sync_cnt <= '0;
          hold     <= 1'b1;
        end
      end else if (sh_done) begin
        inflight <= 1'b0;
        hold     <= 1'b1;
        unique case (ph)
          PH_SYNC: begin
            if (rx_byte == SYNC_BYTE) begin
              ph <= PH_LEN;
            end else if (sync_cnt == SW'(SYNC_LIMIT - 1)) begin
              ph     <= PH_IDLE;
              cs_n   <= 1'b1;
              done   <= 1'b1;
              status <= ST_SYNC_TIMEOUT;
              rx_len <= '0;
            end else begin
              sync_cnt <= sync_cnt + 1'b1;
            end
          end
          PH_LEN: begin
            rlen_cur <= rx_byte;
            pay_n    <= big_n;
            pay_idx  <= '0;
            ph       <= (big_n == 8'd0) ? PH_CRC : PH_PAY;
          end
          PH_PAY: begin
            pay_idx <= pay_idx + 1'b1;
            if (pay_idx == pay_n - 8'd1) ph <= PH_CRC;
          end
          PH_CRC: begin
            crc_ok <= (rx_byte == rx_crc);
            ph     <= PH_ACK;
          end
          PH_ACK: begin
            if (frame_good || (retries == RW'(RETRY_LIMIT))) begin
              ph     <= PH_IDLE;
              cs_n   <= 1'b1;
              done   <= 1'b1;
              status <= frame_good ? ST_OK : ST_RETRY_EXHAUSTED;
              rx_len <= rlen_cur;
            end else begin
              retries  <= retries + 1'b1;
              sync_cnt <= '0;
              ph       <= PH_SYNC;
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  // R1 / R2: with chip select released the clock never toggles
  a_r2_cs_high_sclk_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R3: chip select held low for the whole exchange
  a_r3_cs_low_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !cs_n);

  // R5: payload index stays inside the agreed byte count
  a_r5_pay_index_bound: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_PAY) |-> (pay_idx < pay_n));

  // R7: handshake byte is one of the two codes
  a_r7_handshake_code: assert property (@(posedge clk) disable iff (rst)
    (go && (ph == PH_ACK)) |-> ((tx_byte == ACK_BYTE) || (tx_byte == NACK_BYTE)));

  // R8: retry counter never passes the limit
  a_r8_retry_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (retries <= RW'(RETRY_LIMIT)));

  // R9: ready-wait counter never passes the limit
  a_r9_sync_bound: assert property (@(posedge clk) disable iff (rst)
    (32'(sync_cnt) < SYNC_LIMIT));

  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: reported length moves only with done
  a_r10_rxlen_on_done: assert property (@(posedge clk) disable iff (rst)
    (rx_len != $past(rx_len)) |-> done);

  // R10: done ends the exchange
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && cs_n));

endmodule

// File: tb/test_spi_pkt_engine.sv
module test_spi_pkt_engine;

  localparam int BUF   = 16;
  localparam int RLIM  = 3;
  localparam int SLIM  = 40;
  localparam int AW    = $clog2(BUF);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] tx_len = '0;
  logic tx_wr_en = 1'b0;
  logic [AW-1:0] tx_wr_addr = '0;
  logic [7:0] tx_wr_data = '0;
  logic [AW-1:0] rx_rd_addr = '0;
  logic [7:0] rx_rd_data, rx_len;
  logic done, busy, sclk, mosi, cs_n;
  logic [1:0] status;
  logic miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_pkt_engine #(.BUF_DEPTH(BUF), .HALF_DIV(2), .RETRY_LIMIT(RLIM), .SYNC_LIMIT(SLIM)) i_spi_pkt_engine (
    .clk(clk), .rst(rst), .start(start), .tx_len(tx_len),
    .tx_wr_en(tx_wr_en), .tx_wr_addr(tx_wr_addr), .tx_wr_data(tx_wr_data),
    .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data), .rx_len(rx_len),
    .done(done), .status(status), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  // ---------------- behavioural slave ----------------
  int s_len, s_busy, s_bad, s_nacks;
  bit s_never;
  logic [7:0] s_nval;
  logic [7:0] s_data [32];

  int sst, sb, s_attempt, s_acks, s_sync_total, pidx, pn, bitc;
  logic [7:0] cur, sh, rin, s_crc, m_crc_calc, m_len_seen;
  logic [7:0] m_data_seen [32];
  logic [7:0] m_acks [16];
  bit m_crc_all_good;
  int cs_rises;

  function automatic logic [7:0] sync_out(input int k);
    return (s_never || k < s_busy) ? 8'h00 : 8'hFF;
  endfunction

  task automatic slave_byte(input logic [7:0] rb);
    case (sst)
      0: begin
        s_sync_total++;
        if (cur == 8'hFF) begin
          sst = 1;
          s_crc = 8'h00;
          m_crc_calc = 8'h00;
          cur = 8'(s_len);
        end else begin
          sb++;
          cur = sync_out(sb);
        end
      end
      1: begin
        m_len_seen = rb;
        m_crc_calc = crc_b(m_crc_calc, rb);
        s_crc = crc_b(s_crc, cur);
        pn = (int'(rb) > s_len) ? int'(rb) : s_len;
        pidx = 0;
        if (pn == 0) begin
          sst = 3;
          cur = (s_attempt <= s_bad) ? (s_crc ^ 8'h01) : s_crc;
        end else begin
          sst = 2;
          cur = (s_len > 0) ? s_data[0] : 8'h00;
        end
      end
      2: begin
        m_data_seen[pidx] = rb;
        m_crc_calc = crc_b(m_crc_calc, rb);
        s_crc = crc_b(s_crc, cur);
        pidx++;
        if (pidx == pn) begin
          sst = 3;
          cur = (s_attempt <= s_bad) ? (s_crc ^ 8'h01) : s_crc;
        end else begin
          cur = (pidx < s_len) ? s_data[pidx] : 8'h00;
        end
      end
      3: begin
        if (rb != m_crc_calc) m_crc_all_good = 1'b0;
        sst = 4;
        if (s_attempt <= s_nacks) cur = s_nval;
        else cur = (rb == m_crc_calc) ? 8'hA5 : 8'h5A;
      end
      4: begin
        s_acks++;
        m_acks[s_acks] = rb;
        if (rb == 8'hA5 && cur == 8'hA5) begin
          sst = 5;
          cur = 8'hFF;
        end else begin
          s_attempt++;
          sst = 0;
          sb = 0;
          cur = sync_out(0);
        end
      end
      default: cur = 8'hFF;
    endcase
  endtask

  always @(negedge cs_n) begin
    sst = 0; sb = 0; s_attempt = 1; bitc = 0;
    cur = sync_out(0);
    sh = cur;
    miso = cur[7];
  end

  always @(posedge cs_n) cs_rises++;

  always @(posedge sclk) if (!cs_n) begin
    rin = {rin[6:0], mosi};
    bitc++;
  end

  always @(negedge sclk) if (!cs_n) begin
    if (bitc == 8) begin
      slave_byte(rin);
      sh = cur;
      bitc = 0;
    end else begin
      sh = {sh[6:0], 1'b0};
    end
    miso = sh[7];
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int st;
    int rlen;
    int acks;
    string name;
  } exp_t;
  exp_t sbq[$];
  int mon_seen = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (sbq.size() == 0) begin
          check("R10", 1, 0, "unexpected done");
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(e.st == 0 ? "R10" : (e.st == 1 ? "R8" : "R9"), int'(status), e.st, {e.name, " status"});
          check("R4", int'(rx_len), e.rlen, {e.name, " rx_len"});
          check("R8", s_acks, e.acks, {e.name, " handshake count"});
        end
        @(negedge clk);
        check("R10", int'(done), 0, "done one cycle");
        mon_seen++;
      end
    end
  end

  // ---------------- driver ----------------
  logic [7:0] m_tx [BUF];

  task automatic run_case(input string name, input int tl, input int sl, input int busyb,
                          input bit never, input int bad, input int nacks, input logic [7:0] nval,
                          input int est, input int eacks);
    exp_t e;
    int seen0, prev, n, nst;
    s_len = sl; s_busy = busyb; s_never = never; s_bad = bad; s_nacks = nacks; s_nval = nval;
    s_acks = 0; s_sync_total = 0; m_crc_all_good = 1'b1; cs_rises = 0;
    for (int i = 0; i < 32; i++) s_data[i] = 8'(8'h31 + i * 7 + sl);
    for (int i = 0; i < tl; i++) begin
      m_tx[i] = 8'(8'hC3 ^ (i * 13 + tl));
      @(negedge clk);
      tx_wr_en = 1'b1; tx_wr_addr = AW'(i); tx_wr_data = m_tx[i];
    end
    @(negedge clk);
    tx_wr_en = 1'b0;
    e.st = est; e.rlen = (est == 2) ? 0 : sl; e.acks = eacks; e.name = name;
    sbq.push_back(e);
    prev = int'(rx_len);
    seen0 = mon_seen;
    tx_len = 8'(tl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    check("R10", int'(rx_len), prev, {name, " rx_len held during exchange"});
    check("R3", int'(cs_n), 0, {name, " cs low mid exchange"});
    while (mon_seen == seen0) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R3", cs_rises, 1, {name, " single cs release"});
    check("R1", int'(sclk), 0, {name, " sclk idle after end"});
    if (est == 2) begin
      check("R9", s_sync_total, SLIM, {name, " ready-wait byte count"});
    end else begin
      check("R4", int'(m_len_seen), tl, {name, " length sent"});
      n = (tl > sl) ? tl : sl;
      for (int i = 0; i < n; i++)
        check("R5", int'(m_data_seen[i]), (i < tl) ? int'(m_tx[i]) : 0, {name, " payload sent"});
      check("R6", int'(m_crc_all_good), 1, {name, " crc sent"});
      for (int a = 1; a <= eacks; a++)
        check("R7", int'(m_acks[a]), (a <= bad) ? 8'h5A : 8'hA5, {name, " handshake sent"});
    end
    if (est == 0) begin
      nst = (sl < BUF) ? sl : BUF;
      for (int i = 0; i < nst; i++) begin
        rx_rd_addr = AW'(i);
        @(negedge clk);
        check((sl > BUF) ? "R11" : "R5", int'(rx_rd_data), int'(s_data[i]), {name, " received byte"});
      end
    end
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", int'(cs_n), 1, "reset cs_n");
    check("R1", int'(sclk), 0, "reset sclk");
    check("R1", int'(done), 0, "reset done");
    check("R1", int'(busy), 0, "reset busy");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(status), 0, "idle status");
    check("R1", int'(rx_len), 0, "idle rx_len");
    check("R1", int'(cs_n), 1, "idle cs_n");

    // R3/R4/R5: equal lengths with a late-ready slave
    run_case("equal", 4, 4, 2, 1'b0, 0, 0, 8'h5A, 0, 1);
    // R5: slave shorter, slave pads
    run_case("local_longer", 6, 2, 0, 1'b0, 0, 0, 8'h5A, 0, 1);
    // R5: master has nothing, master pads
    run_case("local_empty", 0, 3, 1, 1'b0, 0, 0, 8'h5A, 0, 1);
    // R5: no payload at all
    run_case("both_empty", 0, 0, 0, 1'b0, 0, 0, 8'h5A, 0, 1);
    // R6/R7/R8: bad slave crc once, master rejects then accepts
    run_case("bad_crc", 3, 5, 0, 1'b0, 1, 0, 8'h5A, 0, 2);
    // R7/R8: slave answers an odd value twice
    run_case("odd_ack", 2, 2, 1, 1'b0, 0, 2, 8'h33, 0, 3);
    // R8: slave always rejects
    run_case("always_nack", 2, 1, 0, 1'b0, 0, 99, 8'h5A, 1, RLIM + 1);
    // R9: slave never ready
    run_case("never_ready", 2, 1, 0, 1'b1, 0, 0, 8'h5A, 2, 0);
    // R11: slave longer than the buffer
    run_case("overflow", 16, 20, 0, 1'b0, 0, 0, 8'h5A, 0, 1);
    finish_up();
  end

endmodule